// File: doc/BRIEF.md
# Programmable Auxiliary Clock Output Generator

This block produces an auxiliary clock output from the internal master clock. An 8-bit control register picks one of four output modes: the master clock halved, the master clock divided by three, a fractional clock at two ninths of the master rate, or a static level taken from a separate configuration input. The output is a registered signal that toggles on master clock edges, so it is glitch-free by construction.

After the initialization reset is released, a start-up counter keeps the output quiet for a parameterized number of master cycles. Once that delay has elapsed and the active-low enable is asserted, the output runs. It keeps running until the enable is deasserted, the test bit is set, or the initialization reset is applied. The mode field can be changed only while the system reset input is held low. Every mode change restarts the divider from its first phase, so the first edge after a change lands in a known cycle.

Top module: `auxclk_gen`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `clk_out_o` is low. The register resets to mode 00 with the test bit cleared, and a later reset returns the block to mode 00.
- R2: `clk_out_o` stays low until START_CYCLES master cycles have passed after the internal, synchronized reset release.
- R3: Mode 00 drives a clock at half the master rate: 1 master cycle high, then 1 low.
- R4: Mode 01 drives a clock at one third of the master rate: 1 master cycle high, then 2 low.
- R5: Mode 10 drives exactly 2 output periods in every 9 master cycles. The repeating pattern is high 2, low 2, high 2, low 3, which gives 4 rising edges in any 18-cycle window.
- R6: Mode 11 drives `clk_out_o` with the value of `level_i`, delayed by one register stage.
- R7: `en_ni` high forces `clk_out_o` low within two cycles. While the start-up delay has elapsed, the test bit is clear and `en_ni` is low, the output keeps running.
- R8: A write takes effect only when `wr_en_i` is high and `wr_cmd_i` equals CMD_CODE. The mode field is data bits 6:5 and is accepted only while `sys_rst_ni` is low. The test bit is data bit 7 and is accepted on any matching write. Data bits 4:0 have no effect.
- R9: A change of the mode field restarts the divider. The output is low for one cycle, then begins at the first phase of the new pattern.
- R10: A set test bit forces `clk_out_o` low within two cycles. Clearing it lets the output resume.
- R11: Toggling `en_ni` preserves the register contents: output resumes in the previously selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal master clock |
| rst_ni | input | 1 | Initialization reset, active low, asserted asynchronously |
| sys_rst_ni | input | 1 | System reset, active low; mode writes are accepted only while low |
| en_ni | input | 1 | Output enable, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_cmd_i | input | 8 | Command code of the write, compared with CMD_CODE |
| wr_data_i | input | 8 | Write data: bit 7 test, bits 6:5 mode |
| level_i | input | 1 | Static level driven in mode 11 |
| clk_out_o | output | 1 | Auxiliary clock output |

## Verification
The `rst_ni` release passes 2 synchronizer stages. The start-up counter then needs START_CYCLES edges, the run flag takes one more edge, and the output register one more. An enable, test-bit or mode change therefore shows at the output two edges after it is sampled. A level change in mode 11 shows one edge after it is sampled. The bench keeps a behavioural model that replays these latencies with integers and pattern strings. It compares against the output at every falling edge, half a period away from the edge on which state changes. Edge-count checks open their windows only after these latencies have elapsed.

// File: rtl/auxclk_pkg.sv
package auxclk_pkg;

  typedef enum logic [1:0] {
    MODE_DIV2  = 2'b00,
    MODE_DIV3  = 2'b01,
    MODE_FRAC  = 2'b10,
    MODE_LEVEL = 2'b11
  } auxclk_mode_e;

  localparam int unsigned DIV2_PERIOD = 2;
  localparam int unsigned DIV3_PERIOD = 3;
  localparam int unsigned FRAC_PERIOD = 9;
  localparam int unsigned PHASE_W     = $clog2(FRAC_PERIOD);

  localparam int unsigned CTRL_TEST_BIT = 7;
  localparam int unsigned CTRL_MODE_LSB = 5;

endpackage

// File: rtl/auxclk_rst_sync.sv
module auxclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/auxclk_ctrl_reg.sv
module auxclk_ctrl_reg
  import auxclk_pkg::*;
#(
  parameter logic [7:0] CMD_CODE = 8'h6C
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sys_rst_ni,
  input  logic         wr_en_i,
  input  logic [7:0]   wr_cmd_i,
  input  logic [7:0]   wr_data_i,
  output auxclk_mode_e mode_o,
  output logic         test_o
);

  logic         hit;
  logic         mode_we;
  logic         test_we;
  auxclk_mode_e mode_q;
  auxclk_mode_e mode_d;
  logic         test_q;
  logic         test_d;
  logic         unused_wr_bits;

  assign hit     = wr_en_i && (wr_cmd_i == CMD_CODE);
  assign mode_we = hit && !sys_rst_ni;
  assign test_we = hit;

  always_comb begin
    mode_d = auxclk_mode_e'(wr_data_i[CTRL_MODE_LSB +: 2]);
    test_d = wr_data_i[CTRL_TEST_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_DIV2;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      test_q <= 1'b0;
    end else if (test_we) begin
      test_q <= test_d;
    end
  end

  assign unused_wr_bits = ^wr_data_i[CTRL_MODE_LSB-1:0];

  assign mode_o = mode_q;
  assign test_o = test_q;

endmodule

// File: rtl/auxclk_startup.sv
module auxclk_startup #(
  parameter int unsigned START_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ready_o
);

  localparam int unsigned CNT_W = $clog2(START_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(START_CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = (cnt_q != CNT_LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ready_o = !cnt_en;

endmodule

// File: rtl/auxclk_divider.sv
module auxclk_divider
  import auxclk_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  auxclk_mode_e mode_i,
  input  logic         level_i,
  output logic         clk_o
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic [PHASE_W-1:0] phase_last;
  auxclk_mode_e       mode_prev_q;
  logic               restart;
  logic               wave;
  logic               out_q;
  logic               out_d;

  assign restart = (mode_i != mode_prev_q);

  always_comb begin
    phase_last = '0;
    wave       = 1'b0;
    unique case (mode_i)
      MODE_DIV2: begin
        phase_last = PHASE_W'(DIV2_PERIOD - 1);
        wave       = (phase_q == '0);
      end
      MODE_DIV3: begin
        phase_last = PHASE_W'(DIV3_PERIOD - 1);
        wave       = (phase_q == '0);
      end
      MODE_FRAC: begin
        phase_last = PHASE_W'(FRAC_PERIOD - 1);
        wave       = (phase_q == PHASE_W'(0)) || (phase_q == PHASE_W'(1)) ||
                     (phase_q == PHASE_W'(4)) || (phase_q == PHASE_W'(5));
      end
      MODE_LEVEL: begin
        phase_last = '0;
        wave       = level_i;
      end
      default: begin
        phase_last = '0;
        wave       = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (!run_i || restart || (phase_q == phase_last)) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + 1'b1;
    end
    out_d = run_i && !restart && wave;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= '0;
      mode_prev_q <= MODE_DIV2;
      out_q       <= 1'b0;
    end else begin
      phase_q     <= phase_d;
      mode_prev_q <= mode_i;
      out_q       <= out_d;
    end
  end

  assign clk_o = out_q;

endmodule

// File: rtl/auxclk_gen.sv
module auxclk_gen
  import auxclk_pkg::*;
#(
  parameter logic [7:0]  CMD_CODE     = 8'h6C,
  parameter int unsigned START_CYCLES = 64,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_rst_ni,
  input  logic       en_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_cmd_i,
  input  logic [7:0] wr_data_i,
  input  logic       level_i,
  output logic       clk_out_o
);

  logic         rst_int_n;
  logic         start_ready;
  logic         test_bit;
  auxclk_mode_e mode_sel;
  logic         run_q;
  logic         run_d;

  auxclk_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_int_n)
  );

  auxclk_ctrl_reg #(
    .CMD_CODE(CMD_CODE)
  ) u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_int_n),
    .sys_rst_ni(sys_rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_cmd_i  (wr_cmd_i),
    .wr_data_i (wr_data_i),
    .mode_o    (mode_sel),
    .test_o    (test_bit)
  );

  auxclk_startup #(
    .START_CYCLES(START_CYCLES)
  ) u_start (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .ready_o(start_ready)
  );

  always_comb begin
    run_d = start_ready && !en_ni && !test_bit;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      run_q <= 1'b0;
    end else begin
      run_q <= run_d;
    end
  end

  auxclk_divider u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .run_i  (run_q),
    .mode_i (mode_sel),
    .level_i(level_i),
    .clk_o  (clk_out_o)
  );

endmodule

// File: rtl/auxclk_gen_chk.sv
module auxclk_gen_chk
  import auxclk_pkg::*;
(
  input logic         clk_i,
  input logic         rst_ni,
  input logic         sys_rst_ni,
  input logic         en_ni,
  input logic         level_i,
  input logic         clk_out_o,
  input logic         run_q,
  input logic         ready,
  input logic         test,
  input auxclk_mode_e mode
);

  // R2
  quiet_before_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready |=> !clk_out_o);

  // R7
  low_when_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_ni) |=> !clk_out_o);

  // R7
  run_latched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !en_ni && !test) |=> run_q);

  // R10
  low_in_test_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(test) |=> !clk_out_o);

  // R8
  mode_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_ni |=> $stable(mode));

  // R6
  level_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && mode == MODE_LEVEL && $past(mode) == MODE_LEVEL) |=> (clk_out_o == $past(level_i)));

endmodule

bind auxclk_gen auxclk_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sys_rst_ni(sys_rst_ni),
  .en_ni     (en_ni),
  .level_i   (level_i),
  .clk_out_o (clk_out_o),
  .run_q     (run_q),
  .ready     (start_ready),
  .test      (test_bit),
  .mode      (mode_sel)
);

// File: tb/tb_auxclk_gen.sv
module tb_auxclk_gen;

  localparam int START = 64;
  localparam logic [7:0] CMD = 8'h6C;

  logic       clk = 1'b0;
  logic       rst_n, sys_rst_n, en_n, wr_en, level;
  logic [7:0] wr_cmd, wr_data;
  logic       clk_out;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  auxclk_gen #(.CMD_CODE(CMD), .START_CYCLES(START), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_ni(sys_rst_n), .en_ni(en_n),
    .wr_en_i(wr_en), .wr_cmd_i(wr_cmd), .wr_data_i(wr_data),
    .level_i(level), .clk_out_o(clk_out)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  string pat [3] = '{"10", "100", "110011000"};
  bit m_s1, m_s2, m_run, m_test, m_out;
  int m_tmr, m_sel, m_prev, m_ph;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_run <= 0; m_test <= 0; m_out <= 0;
      m_tmr <= 0; m_sel <= 0; m_prev <= 0; m_ph <= 0;
    end else begin
      m_s1 <= 1'b1;
      m_s2 <= m_s1;
      if (m_s2) begin
        if (wr_en && wr_cmd == CMD) begin
          m_test <= wr_data[7];
          if (!sys_rst_n) m_sel <= int'(wr_data[6:5]);
        end
        if (m_tmr < START) m_tmr <= m_tmr + 1;
        m_run  <= (m_tmr == START) && !en_n && !m_test;
        m_prev <= m_sel;
        if (!m_run || m_sel != m_prev) begin
          m_out <= 0; m_ph <= 0;
        end else if (m_sel == 3) begin
          m_out <= level; m_ph <= 0;
        end else begin
          m_out <= (pat[m_sel][m_ph] == 8'h31);
          m_ph  <= (m_ph + 1) % pat[m_sel].len();
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic exp_out;
      exp_out = rst_n ? m_out : 1'b0;
      checks++;
      if (clk_out !== exp_out) begin
        errors++;
        $display("FAIL %s cycle compare: actual %0b expected %0b at %0t", cur_req, clk_out, exp_out, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_wait(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic reg_write(input logic [7:0] d, input logic [7:0] cmd, input bit in_sys_rst);
    drive_wait(1);
    sys_rst_n = !in_sys_rst;
    wr_en = 1'b1; wr_cmd = cmd; wr_data = d;
    drive_wait(1);
    wr_en = 1'b0; wr_cmd = 8'h00; wr_data = 8'h00;
    sys_rst_n = 1'b1;
  endtask

  task automatic count_rises(input int n, output int rises);
    logic prev;
    @(negedge clk);
    prev = clk_out;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out && !prev) rises++;
      prev = clk_out;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_run();
  end

  initial begin
    int r;
    rst_n = 0; sys_rst_n = 1; en_n = 0; wr_en = 0; wr_cmd = 0; wr_data = 0; level = 0;

    // R1: reset state
    cur_req = "R1";
    drive_wait(4);
    @(negedge clk);
    check("R1", int'(clk_out), 0, "output during reset");

    // R2: start-up delay
    drive_wait(1);
    rst_n = 1;
    cur_req = "R2";
    count_rises(START, r);
    check("R2", r, 0, "rising edges during start-up window");
    drive_wait(8);

    // R3: divide by 2 (reset mode)
    cur_req = "R3";
    count_rises(20, r);
    check("R3", r, 10, "rising edges in 20 cycles, mode 00");

    // R8: mode write ignored while system reset is high
    cur_req = "R8";
    reg_write(8'h20, CMD, 1'b0);
    drive_wait(3);
    count_rises(20, r);
    check("R8", r, 10, "mode write outside system reset");
    // R8: wrong command code ignored
    reg_write(8'h20, CMD ^ 8'h10, 1'b1);
    drive_wait(3);
    count_rises(20, r);
    check("R8", r, 10, "write with wrong command code");

    // R9 then R4: change to divide by 3
    cur_req = "R9";
    reg_write(8'h20, CMD, 1'b1);
    drive_wait(12);
    cur_req = "R4";
    count_rises(30, r);
    check("R4", r, 10, "rising edges in 30 cycles, mode 01");

    // R5: fractional 2/9, bit 0 set must be harmless (R8)
    cur_req = "R9";
    reg_write(8'h41, CMD, 1'b1);
    drive_wait(12);
    cur_req = "R5";
    count_rises(18, r);
    check("R5", r, 4, "rising edges in 18 cycles, mode 10");
    count_rises(36, r);
    check("R5", r, 8, "rising edges in 36 cycles, mode 10");

    // R6: static level
    cur_req = "R6";
    reg_write(8'h60, CMD, 1'b1);
    level = 1;
    drive_wait(4);
    @(negedge clk);
    check("R6", int'(clk_out), 1, "level high in mode 11");
    drive_wait(1);
    level = 0;
    drive_wait(2);
    @(negedge clk);
    check("R6", int'(clk_out), 0, "level low in mode 11");

    // R7 / R11: enable toggling preserves mode
    cur_req = "R7";
    reg_write(8'h40, CMD, 1'b1);
    drive_wait(10);
    en_n = 1;
    drive_wait(2);
    count_rises(15, r);
    check("R7", r, 0, "rising edges while disabled");
    en_n = 0;
    drive_wait(12);
    cur_req = "R11";
    count_rises(36, r);
    check("R11", r, 8, "mode 10 kept across enable toggle");

    // R10: test bit forces low
    cur_req = "R10";
    reg_write(8'hC0, CMD, 1'b0);
    drive_wait(2);
    count_rises(20, r);
    check("R10", r, 0, "rising edges with test bit set");
    reg_write(8'h40, CMD, 1'b0);
    drive_wait(12);
    count_rises(36, r);
    check("R10", r, 8, "output resumes after test bit cleared");

    // R1: reset mid-run returns to mode 00
    cur_req = "R1";
    drive_wait(1);
    rst_n = 0;
    @(negedge clk);
    check("R1", int'(clk_out), 0, "output right after reset assertion");
    drive_wait(3);
    rst_n = 1;
    drive_wait(START + 8);
    count_rises(20, r);
    check("R1", r, 10, "mode 00 after second reset");

    finish_run();
  end

endmodule